// File: doc/BRIEF.md
# Pipelined Multiply-Add with Late Accumulator

This block is a three-stage, 32-bit integer multiply-add pipe. Each cycle it can take one operation carrying two multiplier operands, an addend, a destination tag and the tag of the register that supplied the addend. Three cycles later it returns the low word of `a*b + c` together with the destination tag. There is no handshake. The issuing scheduler decides when to present an operation, and the pipe never stalls.

The product is formed over the first two stages. The addend is not needed until the last stage. When the operation issued in the cycle just before wrote the register that this operation's addend comes from, the pipe takes the addend from its own final-stage result and ignores the value presented on `issue_c`. A chain of accumulations, where each result is the next addend, therefore completes one operation per cycle. A multiplier operand that depends on an in-flight result must wait until that result has left the pipe.

Top module: `lam_madd`

## Requirements
- R1: For an operation without forwarding, `result_data` equals the low 32 bits of `issue_a*issue_b + issue_c`, including the operand values 0xFFFFFFFF and 0x80000000.
- R2: An operation can be issued on every cycle. Back-to-back independent operations return results on consecutive cycles, in issue order.
- R3: An operation sampled with `issue_valid` high at rising edge k shows `result_valid` high after rising edge k+2, and only for that one cycle.
- R4: `result_tag` equals the `issue_tag` of the operation whose result is being presented.
- R5: If the operation issued exactly one cycle earlier was valid and its `issue_tag` equals the present `issue_c_tag`, the addend is that earlier operation's result and `issue_c` has no effect. A chain of such operations yields one result per cycle.
- R6: A tag match with an operation issued two or more cycles earlier, or across a bubble, does not forward: `issue_c` is used as the addend.
- R7: A cycle with `issue_valid` low produces `result_valid` low three cycles later.
- R8: Synchronous active-high `rst` discards every in-flight operation. None of them produces a result, and none of them forwards to an operation issued after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| issue_tag | input | TAG_W | Destination tag of the operation |
| issue_c_tag | input | TAG_W | Tag of the register that supplied the addend |
| issue_a | input | DATA_W | Multiplicand |
| issue_b | input | DATA_W | Multiplier |
| issue_c | input | DATA_W | Addend value from the register file |
| result_valid | output | 1 | A result is presented |
| result_tag | output | TAG_W | Destination tag of the result |
| result_data | output | DATA_W | Low word of the multiply-add |

## Verification
A valid bit or tag that is dropped or delayed inside the pipe shows up three cycles after issue: the result slot is missing, lands on the wrong cycle, or carries a foreign tag. A stale or wrongly qualified forwarding decision corrupts `result_data` on the very cycle that operation leaves. In an accumulation chain the error then carries into every later link, so a chain makes a single bad forward visible on each following cycle. A bubble or a reset that fails to clear the final-stage valid bit shows up as a wrong value on the first operation after it whose addend tag happens to match.

// File: rtl/lam_pkg.sv
package lam_pkg;

  parameter int unsigned LAM_DW = 32;

  // Low word of a product; operands are equal width so the truncation is implicit.
  function automatic logic [LAM_DW-1:0] lam_mul_lo(input logic [LAM_DW-1:0] x,
                                                   input logic [LAM_DW-1:0] y);
    return x * y;
  endfunction

  // Low word of product plus addend, wrapping modulo 2^LAM_DW.
  function automatic logic [LAM_DW-1:0] lam_madd_lo(input logic [LAM_DW-1:0] x,
                                                    input logic [LAM_DW-1:0] y,
                                                    input logic [LAM_DW-1:0] z);
    return lam_mul_lo(x, y) + z;
  endfunction

endpackage

// File: rtl/lam_mul_front.sv
// Stages 1 and 2: operand capture, then the registered product.
module lam_mul_front #(
  parameter int unsigned DATA_W = lam_pkg::LAM_DW,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [TAG_W-1:0]  in_ctag,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_c,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [TAG_W-1:0]  out_ctag,
  output logic [DATA_W-1:0] out_c,
  output logic [DATA_W-1:0] out_prod
);

  logic              s1_v;
  logic [TAG_W-1:0]  s1_tag, s1_ctag;
  logic [DATA_W-1:0] s1_a, s1_b, s1_c;
  logic [DATA_W-1:0] s1_prod;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= in_valid;
    s1_tag  <= in_tag;
    s1_ctag <= in_ctag;
    s1_a    <= in_a;
    s1_b    <= in_b;
    s1_c    <= in_c;
  end

  assign s1_prod = lam_pkg::lam_mul_lo(s1_a, s1_b);

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_v;
    out_tag  <= s1_tag;
    out_ctag <= s1_ctag;
    out_c    <= s1_c;
    out_prod <= s1_prod;
  end

  AST_FRONT_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2)); // R3

endmodule

// File: rtl/lam_acc_back.sv
// Stage 3: late addend with a forward from this stage's own result.
module lam_acc_back #(
  parameter int unsigned DATA_W = lam_pkg::LAM_DW,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [TAG_W-1:0]  in_ctag,
  input  logic [DATA_W-1:0] in_c,
  input  logic [DATA_W-1:0] in_prod,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data,
  output logic              byp_hit
);

  logic [DATA_W-1:0] addend_sel;
  logic [DATA_W-1:0] sum_next;

  assign byp_hit    = in_valid && res_valid && (in_ctag == res_tag);
  assign addend_sel = byp_hit ? res_data : in_c;
  assign sum_next   = in_prod + addend_sel;

  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= in_valid;
    res_tag  <= in_tag;
    res_data <= sum_next;
  end

  AST_NO_RESULT_FROM_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid); // R7

endmodule

// File: rtl/lam_madd.sv
module lam_madd #(
  parameter int unsigned DATA_W = lam_pkg::LAM_DW,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [TAG_W-1:0]  issue_tag,
  input  logic [TAG_W-1:0]  issue_c_tag,
  input  logic [DATA_W-1:0] issue_a,
  input  logic [DATA_W-1:0] issue_b,
  input  logic [DATA_W-1:0] issue_c,
  output logic              result_valid,
  output logic [TAG_W-1:0]  result_tag,
  output logic [DATA_W-1:0] result_data
);

  logic              mid_valid;
  logic [TAG_W-1:0]  mid_tag, mid_ctag;
  logic [DATA_W-1:0] mid_c, mid_prod;
  logic              fwd_taken;

  lam_mul_front #(.DATA_W(DATA_W), .TAG_W(TAG_W)) front_i (
    .clk(clk), .rst(rst),
    .in_valid(issue_valid), .in_tag(issue_tag), .in_ctag(issue_c_tag),
    .in_a(issue_a), .in_b(issue_b), .in_c(issue_c),
    .out_valid(mid_valid), .out_tag(mid_tag), .out_ctag(mid_ctag),
    .out_c(mid_c), .out_prod(mid_prod)
  );

  lam_acc_back #(.DATA_W(DATA_W), .TAG_W(TAG_W)) back_i (
    .clk(clk), .rst(rst),
    .in_valid(mid_valid), .in_tag(mid_tag), .in_ctag(mid_ctag),
    .in_c(mid_c), .in_prod(mid_prod),
    .res_valid(result_valid), .res_tag(result_tag), .res_data(result_data),
    .byp_hit(fwd_taken)
  );

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(issue_valid, 3)); // R3

  AST_TAG_CARRIED: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> result_tag == $past(issue_tag, 3)); // R4

  AST_PLAIN_SUM: assert property (@(posedge clk) disable iff (rst)
    (result_valid && !$past(fwd_taken)) |->
      result_data == lam_pkg::lam_madd_lo($past(issue_a, 3), $past(issue_b, 3),
                                          $past(issue_c, 3))); // R1

  AST_CHAIN_SUM: assert property (@(posedge clk) disable iff (rst)
    (result_valid && $past(fwd_taken)) |->
      result_data == lam_pkg::lam_madd_lo($past(issue_a, 3), $past(issue_b, 3),
                                          $past(result_data))); // R5

  AST_FORWARD_ONLY_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    fwd_taken |-> ($past(issue_valid, 2) && $past(issue_valid, 3) &&
                   $past(issue_c_tag, 2) == $past(issue_tag, 3))); // R6

endmodule

// File: tb/lam_madd_tb_top.sv
module lam_madd_tb_top;
  localparam int TW = 4;
  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic iv = 1'b0;
  logic [TW-1:0] itag = '0, ictag = '0;
  logic [31:0] ia = '0, ib = '0, ic = '0;
  logic rv;
  logic [TW-1:0] rtag;
  logic [31:0] rdata;

  lam_madd #(.DATA_W(32), .TAG_W(TW)) dut_i (
    .clk(clk), .rst(rst), .issue_valid(iv), .issue_tag(itag), .issue_c_tag(ictag),
    .issue_a(ia), .issue_b(ib), .issue_c(ic),
    .result_valid(rv), .result_tag(rtag), .result_data(rdata)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic ev [DEPTH];
  logic [TW-1:0] et [DEPTH];
  logic [31:0] ed [DEPTH];
  string er [DEPTH];

  function automatic logic [31:0] ref_madd(input logic [31:0] a, b, c);
    logic [63:0] w;
    w = {32'd0, a} * {32'd0, b};
    return w[31:0] + c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // One cycle: sample the output owed by the entry issued three cycles ago, then drive.
  task automatic tick(input logic v, input logic [TW-1:0] tg, ctg,
                      input logic [31:0] a, b, c, input logic r, input string kind);
    bit byp;
    @(negedge clk);
    if (cyc >= 3) begin
      int k = cyc - 3;
      check(rv === ev[k], ev[k] ? "R3" : "R7", "result_valid", {31'd0, rv}, {31'd0, ev[k]});
      if (ev[k]) begin
        check(rtag === et[k], "R4", "result_tag", 32'(rtag), 32'(et[k]));
        check(rdata === ed[k], er[k], "result_data", rdata, ed[k]);
      end
    end
    rst = r; iv = v; itag = tg; ictag = ctg; ia = a; ib = b; ic = c;
    if (r) begin
      ev[cyc] = 1'b0;
      if (cyc >= 1) ev[cyc-1] = 1'b0;
      if (cyc >= 2) ev[cyc-2] = 1'b0;
    end else begin
      ev[cyc] = v;
      byp = (cyc >= 1) && ev[cyc-1] && (et[cyc-1] == ctg);
      et[cyc] = tg;
      ed[cyc] = ref_madd(a, b, byp ? ed[cyc-1] : c);
      er[cyc] = byp ? "R5" : kind;
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, '0, '0, '0, '0, '0, 1'b0, "R7");
  endtask

  initial begin
    #(20 * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ev[i] = 1'b0;
    for (int i = 0; i < 4; i++) tick(1'b0, '0, '0, '0, '0, '0, 1'b1, "R8");
    @(negedge clk);
    check(rv === 1'b0, "R8", "valid after reset", {31'd0, rv}, 32'd0);
    // Corner operands, addend tag F never matches (tags stay below F here).
    tick(1'b1, 4'd1, 4'hF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 1'b0, "R1");
    tick(1'b1, 4'd2, 4'hF, 32'h80000000, 32'h2, 32'h0, 1'b0, "R1");
    tick(1'b1, 4'd3, 4'hF, 32'h80000000, 32'h80000000, 32'hFFFFFFFF, 1'b0, "R1");
    tick(1'b1, 4'd4, 4'hF, 32'hFFFFFFFF, 32'h1, 32'h1, 1'b0, "R1");
    tick(1'b1, 4'd5, 4'hF, 32'h0, 32'h12345678, 32'h7, 1'b0, "R1");
    tick(1'b1, 4'd6, 4'hF, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b0, "R1");
    idle(3);
    // Eight independent back-to-back operations.
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++)
      tick(1'b1, 4'(i), 4'hF, $urandom, $urandom, $urandom, 1'b0, "R2");
    idle(3);
    // Accumulation chain: issue_c carries garbage that must be ignored.
    tick(1'b1, 4'd0, 4'hF, 32'd3, 32'd5, 32'd100, 1'b0, "R1");
    for (int i = 1; i < 12; i++)
      tick(1'b1, 4'(i % 8), 4'((i - 1) % 8), $urandom, $urandom, 32'hDEADBEEF, 1'b0, "R5");
    idle(3);
    // No forward across a bubble, nor from two cycles back.
    tick(1'b1, 4'd3, 4'hF, 32'd7, 32'd9, 32'd1, 1'b0, "R6");
    tick(1'b0, 4'd3, 4'hF, 32'd0, 32'd0, 32'd0, 1'b0, "R7");
    tick(1'b1, 4'd4, 4'd3, 32'd2, 32'd2, 32'd50, 1'b0, "R6");
    tick(1'b1, 4'd5, 4'hF, 32'd6, 32'd6, 32'd0, 1'b0, "R6");
    tick(1'b1, 4'd6, 4'hF, 32'd1, 32'd1, 32'd0, 1'b0, "R6");
    tick(1'b1, 4'd7, 4'd5, 32'd10, 32'd10, 32'd5, 1'b0, "R6");
    idle(3);
    // Random mix with narrow tags so forwarding and bubbles are frequent.
    for (int i = 0; i < 300; i++)
      tick(($urandom % 5) != 0, 4'($urandom % 4), 4'($urandom % 4),
           ($urandom % 8 == 0) ? 32'hFFFFFFFF : $urandom,
           ($urandom % 8 == 0) ? 32'h80000000 : $urandom, $urandom, 1'b0, "R1");
    idle(3);
    // Reset with work in flight; the next op's addend tag names a discarded op.
    tick(1'b1, 4'd9, 4'hF, 32'd11, 32'd13, 32'd1, 1'b0, "R8");
    tick(1'b1, 4'd10, 4'hF, 32'd17, 32'd19, 32'd1, 1'b0, "R8");
    tick(1'b0, 4'd0, 4'd0, 32'd0, 32'd0, 32'd0, 1'b1, "R8");
    tick(1'b1, 4'd11, 4'd10, 32'd4, 32'd4, 32'd9, 1'b0, "R8");
    idle(5);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule